// File: doc/BRIEF.md
# Synchronous DDCMP Message Receiver with Address Filtering

This block turns a serial line into framed DDCMP messages. Each bit comes in on `rxd`, qualified by a one-cycle receive-clock enable. The block can first undo NRZI line coding. Next it slides a 16-bit window over the bit stream until the two programmed sync characters appear in a row, which fixes the byte boundary. It then assembles bytes and discards each one until it sees a message start character.

A message consists of a six-byte header, a header CRC, and for data messages a data field with its own CRC. The header is held in local storage until its CRC and its address byte have both been judged. A message that passes both is then replayed onto the output byte stream, followed by its data bytes. A completion status word reports a data CRC error or a carrier abort.

Four saturating error counters record:
- header CRC failures
- data CRC failures
- messages dropped on address
- carrier-loss aborts

After every message, whether it is accepted, dropped or aborted, the receiver goes back to hunting for sync bit by bit.

Top module: `ddcmp_rx`

## Requirements
- R1: When `nrzi_sel` is 1 a received bit is 1 if the line level equals the level at the previous enabled bit and 0 if it changed; the reference level is 1 after reset. When `nrzi_sel` is 0, `rxd` is the bit itself.
- R2: Bits are taken least significant first. No byte is assembled until the last 16 bits hold `syn1` followed by `syn2`, so a message sent without that pair produces no output.
- R3: Once in sync, only 0x81, 0x05 or 0x90 opens a message; any other byte is dropped and the search continues.
- R4: The header is six bytes plus two CRC bytes, low byte first. The CRC is CRC-16 in reflected form (polynomial 0xA001, initial value 0) and the whole eight bytes must leave a zero remainder. On failure nothing is output and error counter 0 increments.
- R5: Header byte 6 is the address. It matches entry i when `((addr ^ addr_cmp[i]) & ~addr_msk[i]) == 0`, where entry i occupies bits 8i+7..8i and a mask bit of 1 means "don't care". If the CRC is good but no entry matches, nothing is output and error counter 2 increments.
- R6: For an accepted message the six header bytes appear on `out_data` in order, one per clock, with `out_first` on byte 1. For a message opened by 0x05, or whose count is zero, `out_last` marks byte 6 and `stat_vld` pulses with status 0 in the same cycle.
- R7: The byte count is header byte 2 plus bits 5..0 of byte 3 times 256. When the message is not opened by 0x05 and the count is nonzero, that many data bytes follow the header bytes on the output, with `out_last` on the final one. After the two data CRC bytes, `stat_vld` pulses with `stat_word[0]` = 1 on a nonzero remainder, and in that case error counter 1 increments.
- R8: If `cd` falls while a message is in progress, the message is abandoned, error counter 3 increments and the receiver hunts for sync again. If that message had already been accepted, `stat_vld` pulses with `stat_word[1]` = 1.
- R9: Error counter k occupies `err_cnt` bits k*CNT_W+CNT_W-1..k*CNT_W. It holds at all ones rather than wrapping, and returns to zero the clock after `cnt_clr[k]`; a clear wins over a simultaneous increment.
- R10: While `rx_en` is 0 the receiver ignores the line, produces no output, counts nothing and loses sync.
- R11: After reset `out_vld`, `stat_vld` and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| bit_en | input | 1 | One-cycle strobe marking a valid line bit |
| rxd | input | 1 | Serial line level |
| cd | input | 1 | Carrier detect, active high |
| nrzi_sel | input | 1 | 1 selects NRZI decoding |
| syn1 | input | 8 | First sync character |
| syn2 | input | 8 | Second sync character |
| addr_cmp | input | 8*NUM_ADDR | Address compare values |
| addr_msk | input | 8*NUM_ADDR | Address masks, 1 = ignore bit |
| cnt_clr | input | 4 | Per-counter clear strobes |
| out_vld | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_first | output | 1 | First byte of a message |
| out_last | output | 1 | Last byte of a message |
| stat_vld | output | 1 | Completion status strobe |
| stat_word | output | 2 | Bit 0 data CRC error, bit 1 carrier abort |
| err_cnt | output | 4*CNT_W | Error counters 0..3 |

## Verification
A byte is ready inside the block one clock after the enable of its eighth bit. A data byte, a status pulse or a counter step then lands on the next edge, two clocks after that enable. The six header bytes are replayed on the six clocks after the clock on which the header decision is taken. A carrier loss produces its status and count one clock after `cd` is seen low. The bench never samples at these edges. It records every output cycle at the falling clock edge and compares the record only after three idle bytes, which is 48 clocks and far longer than any of these delays.

// File: rtl/ddcmp_rx_pkg.sv
package ddcmp_rx_pkg;

   localparam logic [7:0] CH_SOH   = 8'h81;
   localparam logic [7:0] CH_ENQ   = 8'h05;
   localparam logic [7:0] CH_DLE   = 8'h90;
   localparam int         HDR_LEN  = 6;
   localparam int         LEN_W    = 14;
   localparam int         NUM_ERR  = 4;
   localparam int         EC_HCRC  = 0;
   localparam int         EC_DCRC  = 1;
   localparam int         EC_ADDR  = 2;
   localparam int         EC_CD    = 3;

   typedef enum logic [2:0] {
      ST_SRCH,
      ST_HDR,
      ST_HCRC,
      ST_REPLAY,
      ST_DATA,
      ST_DCRC
   } rx_st_e;

   function automatic logic [15:0] crc16_upd(input logic [15:0] c_in, input logic [7:0] d);
      logic [15:0] c;
      c = c_in;
      for (int i = 0; i < 8; i++) begin
         if (c[0] ^ d[i]) c = (c >> 1) ^ 16'hA001;
         else             c = c >> 1;
      end
      return c;
   endfunction

endpackage

// File: rtl/ddcmp_line_dec.sv
module ddcmp_line_dec #(
   parameter bit HAS_NRZI = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic rxd,
   input  logic nrzi_sel,
   output logic dbit
);
   generate
      if (HAS_NRZI) begin : g_nrzi
         logic prev_lvl;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      prev_lvl <= 1'b1;
            else if (bit_en) prev_lvl <= rxd;
         end
         assign dbit = nrzi_sel ? ~(rxd ^ prev_lvl) : rxd;
      end else begin : g_nrz
         logic unused_sel;
         assign unused_sel = nrzi_sel ^ clk ^ rst_n ^ bit_en;
         assign dbit = rxd;
      end
   endgenerate
endmodule

// File: rtl/ddcmp_framer.sv
module ddcmp_framer (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic       dbit,
   input  logic [7:0] syn1,
   input  logic [7:0] syn2,
   input  logic       resync,
   output logic       in_sync,
   output logic       byte_vld,
   output logic [7:0] byte_d
);
   logic [15:0] hunt_sr;
   logic [15:0] hunt_nx;
   logic [7:0]  asm_sr;
   logic [2:0]  bcnt;

   assign hunt_nx = {dbit, hunt_sr[15:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hunt_sr  <= '0;
         asm_sr   <= '0;
         bcnt     <= '0;
         in_sync  <= 1'b0;
         byte_vld <= 1'b0;
         byte_d   <= '0;
      end else begin
         byte_vld <= 1'b0;
         if (resync) begin
            hunt_sr <= '0;
            bcnt    <= '0;
            in_sync <= 1'b0;
         end else if (bit_en) begin
            if (!in_sync) begin
               hunt_sr <= hunt_nx;
               if (hunt_nx == {syn2, syn1}) begin
                  in_sync <= 1'b1;
                  bcnt    <= '0;
               end
            end else begin
               asm_sr <= {dbit, asm_sr[7:1]};
               bcnt   <= bcnt + 3'd1;
               if (bcnt == 3'd7) begin
                  byte_vld <= 1'b1;
                  byte_d   <= {dbit, asm_sr[7:1]};
               end
            end
         end
      end
   end
endmodule

// File: rtl/ddcmp_addr_match.sv
module ddcmp_addr_match #(
   parameter int NUM_ADDR = 4
) (
   input  logic [7:0]            addr,
   input  logic [NUM_ADDR*8-1:0] cmp,
   input  logic [NUM_ADDR*8-1:0] msk,
   output logic                  hit
);
   logic [NUM_ADDR-1:0] hit_vec;

   for (genvar i = 0; i < NUM_ADDR; i++) begin : g_cmp
      assign hit_vec[i] = (((addr ^ cmp[i*8 +: 8]) & ~msk[i*8 +: 8]) == 8'h00);
   end

   assign hit = |hit_vec;
endmodule

// File: rtl/ddcmp_err_ctr.sv
module ddcmp_err_ctr #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (clr)               cnt <= '0;
      else if (inc && cnt != '1)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/ddcmp_rx.sv
module ddcmp_rx
   import ddcmp_rx_pkg::*;
#(
   parameter int NUM_ADDR = 4,
   parameter int CNT_W    = 16,
   parameter bit HAS_NRZI = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      rx_en,
   input  logic                      bit_en,
   input  logic                      rxd,
   input  logic                      cd,
   input  logic                      nrzi_sel,
   input  logic [7:0]                syn1,
   input  logic [7:0]                syn2,
   input  logic [NUM_ADDR*8-1:0]     addr_cmp,
   input  logic [NUM_ADDR*8-1:0]     addr_msk,
   input  logic [NUM_ERR-1:0]        cnt_clr,
   output logic                      out_vld,
   output logic [7:0]                out_data,
   output logic                      out_first,
   output logic                      out_last,
   output logic                      stat_vld,
   output logic [1:0]                stat_word,
   output logic [NUM_ERR*CNT_W-1:0]  err_cnt
);
   localparam int RP_W = $clog2(HDR_LEN);

   initial begin
      assert (NUM_ADDR >= 1 && NUM_ADDR <= 8);
      assert (CNT_W >= 2 && CNT_W <= 32);
   end

   logic              dbit, bit_q, quiet, resync, fin;
   logic              in_sync, byte_vld, addr_hit;
   logic [7:0]        byte_d;
   logic [7:0]        hdr [HDR_LEN];
   rx_st_e            st;
   logic [2:0]        idx;
   logic [RP_W-1:0]   rp;
   logic [15:0]       crc, crc_nx;
   logic [LEN_W-1:0]  dcnt, hdr_len;
   logic              is_start, has_data, abort;
   logic              hcrc_end, hdr_drop, dcrc_end, rp_done;
   logic [NUM_ERR-1:0] inc;

   assign quiet  = !rx_en || !cd;
   assign bit_q  = bit_en && !quiet;

   ddcmp_line_dec #(.HAS_NRZI(HAS_NRZI)) u_dec (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_q), .rxd(rxd),
      .nrzi_sel(nrzi_sel), .dbit(dbit)
   );

   ddcmp_framer u_frm (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_q), .dbit(dbit),
      .syn1(syn1), .syn2(syn2), .resync(resync),
      .in_sync(in_sync), .byte_vld(byte_vld), .byte_d(byte_d)
   );

   ddcmp_addr_match #(.NUM_ADDR(NUM_ADDR)) u_am (
      .addr(hdr[HDR_LEN-1]), .cmp(addr_cmp), .msk(addr_msk), .hit(addr_hit)
   );

   always_comb begin
      is_start = (byte_d == CH_SOH) || (byte_d == CH_ENQ) || (byte_d == CH_DLE);
      hdr_len  = {hdr[2][5:0], hdr[1]};
      has_data = (hdr[0] != CH_ENQ) && (hdr_len != '0);
      crc_nx   = crc16_upd(crc, byte_d);
      abort    = rx_en && !cd && (st != ST_SRCH);
      hcrc_end = byte_vld && (st == ST_HCRC) && idx[0];
      hdr_drop = hcrc_end && ((crc_nx != 16'h0) || !addr_hit);
      dcrc_end = byte_vld && (st == ST_DCRC) && idx[0];
      rp_done  = (st == ST_REPLAY) && (rp == RP_W'(HDR_LEN-1)) && !has_data;
      fin      = hdr_drop || dcrc_end || rp_done;
      resync   = quiet || (fin && in_sync);
      inc          = '0;
      inc[EC_HCRC] = hcrc_end && (crc_nx != 16'h0);
      inc[EC_ADDR] = hcrc_end && (crc_nx == 16'h0) && !addr_hit;
      inc[EC_DCRC] = dcrc_end && (crc_nx != 16'h0);
      inc[EC_CD]   = abort;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_SRCH;
         idx       <= '0;
         rp        <= '0;
         crc       <= '0;
         dcnt      <= '0;
         out_vld   <= 1'b0;
         out_data  <= '0;
         out_first <= 1'b0;
         out_last  <= 1'b0;
         stat_vld  <= 1'b0;
         stat_word <= '0;
         for (int i = 0; i < HDR_LEN; i++) hdr[i] <= '0;
      end else begin
         out_vld   <= 1'b0;
         out_first <= 1'b0;
         out_last  <= 1'b0;
         stat_vld  <= 1'b0;
         if (quiet) begin
            st <= ST_SRCH;
            if (abort && (st == ST_REPLAY || st == ST_DATA || st == ST_DCRC)) begin
               stat_vld  <= 1'b1;
               stat_word <= 2'b10;
            end
         end else begin
            case (st)
               ST_SRCH: if (byte_vld && in_sync && is_start) begin
                  hdr[0] <= byte_d;
                  crc    <= crc16_upd(16'h0, byte_d);
                  idx    <= 3'd1;
                  st     <= ST_HDR;
               end
               ST_HDR: if (byte_vld) begin
                  hdr[idx] <= byte_d;
                  crc      <= crc_nx;
                  if (idx == 3'(HDR_LEN-1)) begin
                     idx <= '0;
                     st  <= ST_HCRC;
                  end else begin
                     idx <= idx + 3'd1;
                  end
               end
               ST_HCRC: if (byte_vld) begin
                  crc <= crc_nx;
                  idx <= 3'd1;
                  if (hcrc_end) begin
                     rp <= '0;
                     st <= hdr_drop ? ST_SRCH : ST_REPLAY;
                  end
               end
               ST_REPLAY: begin
                  out_vld   <= 1'b1;
                  out_data  <= hdr[rp];
                  out_first <= (rp == '0);
                  out_last  <= rp_done;
                  if (rp == RP_W'(HDR_LEN-1)) begin
                     if (has_data) begin
                        st   <= ST_DATA;
                        dcnt <= '0;
                        crc  <= '0;
                     end else begin
                        stat_vld  <= 1'b1;
                        stat_word <= 2'b00;
                        st        <= ST_SRCH;
                     end
                  end else begin
                     rp <= rp + 1'b1;
                  end
               end
               ST_DATA: if (byte_vld) begin
                  out_vld  <= 1'b1;
                  out_data <= byte_d;
                  out_last <= (dcnt == hdr_len - 1'b1);
                  crc      <= crc_nx;
                  dcnt     <= dcnt + 1'b1;
                  if (dcnt == hdr_len - 1'b1) begin
                     idx <= '0;
                     st  <= ST_DCRC;
                  end
               end
               ST_DCRC: if (byte_vld) begin
                  crc <= crc_nx;
                  idx <= 3'd1;
                  if (dcrc_end) begin
                     stat_vld  <= 1'b1;
                     stat_word <= {1'b0, crc_nx != 16'h0};
                     st        <= ST_SRCH;
                  end
               end
               default: st <= ST_SRCH;
            endcase
         end
      end
   end

   for (genvar k = 0; k < NUM_ERR; k++) begin : g_ctr
      ddcmp_err_ctr #(.W(CNT_W)) u_ctr (
         .clk(clk), .rst_n(rst_n), .inc(inc[k]), .clr(cnt_clr[k]),
         .cnt(err_cnt[k*CNT_W +: CNT_W])
      );
   end
endmodule

// File: rtl/ddcmp_rx_chk.sv
module ddcmp_rx_chk #(
   parameter int CNT_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rx_en,
   input logic               cd,
   input logic [3:0]         cnt_clr,
   input logic               out_vld,
   input logic               out_first,
   input logic               out_last,
   input logic               stat_vld,
   input logic [1:0]         stat_word,
   input logic [4*CNT_W-1:0] err_cnt
);
   // R6
   first_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_first || out_last) |-> out_vld);

   // R8
   abort_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_vld && stat_word[1]) |-> $past(!cd));

   // R8
   carrier_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cd |=> !out_vld);

   // R10
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (!out_vld && !stat_vld));

   for (genvar i = 0; i < 4; i++) begin : g_c
      // R9
      cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_clr[i] |=> (err_cnt[i*CNT_W +: CNT_W] == '0));
      // R9
      cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((err_cnt[i*CNT_W +: CNT_W] == '1) && !cnt_clr[i]) |=> (err_cnt[i*CNT_W +: CNT_W] == '1));
      // R9
      cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !cnt_clr[i] |=> (err_cnt[i*CNT_W +: CNT_W] >= $past(err_cnt[i*CNT_W +: CNT_W])));
   end
endmodule

bind ddcmp_rx ddcmp_rx_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cd(cd), .cnt_clr(cnt_clr),
   .out_vld(out_vld), .out_first(out_first), .out_last(out_last),
   .stat_vld(stat_vld), .stat_word(stat_word), .err_cnt(err_cnt)
);

// File: tb/ddcmp_rx_bench.sv
module ddcmp_rx_bench;
   localparam int NA = 4;
   localparam int CW = 3;
   localparam logic [7:0] SYN = 8'h96;

   logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0, bit_en = 1'b0, rxd = 1'b1;
   logic cd = 1'b1, nrzi_sel = 1'b0;
   logic [7:0] syn1 = SYN, syn2 = SYN;
   logic [NA*8-1:0] addr_cmp = {8'hC3, 8'hA0, 8'h10, 8'h01};
   logic [NA*8-1:0] addr_msk = {8'h00, 8'h00, 8'h0F, 8'h00};
   logic [3:0] cnt_clr = '0;
   logic out_vld, out_first, out_last, stat_vld;
   logic [7:0] out_data;
   logic [1:0] stat_word;
   logic [4*CW-1:0] err_cnt;

   always #5 clk = ~clk;

   ddcmp_rx #(.NUM_ADDR(NA), .CNT_W(CW)) u_ddcmp_rx (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_en(bit_en), .rxd(rxd),
      .cd(cd), .nrzi_sel(nrzi_sel), .syn1(syn1), .syn2(syn2),
      .addr_cmp(addr_cmp), .addr_msk(addr_msk), .cnt_clr(cnt_clr),
      .out_vld(out_vld), .out_data(out_data), .out_first(out_first),
      .out_last(out_last), .stat_vld(stat_vld), .stat_word(stat_word),
      .err_cnt(err_cnt)
   );

   int tests = 0, fails = 0;
   bit done = 1'b0;
   logic line = 1'b1;
   int ec [4];

   // capture of everything the block emits
   logic [7:0] cap_d [64];
   logic       cap_f [64];
   logic       cap_l [64];
   int         ncap = 0, nstat = 0;
   logic [1:0] last_stat = '0;

   always @(negedge clk) begin
      if (out_vld && ncap < 64) begin
         cap_d[ncap] = out_data;
         cap_f[ncap] = out_first;
         cap_l[ncap] = out_last;
         ncap++;
      end
      if (stat_vld) begin
         nstat++;
         last_stat = stat_word;
      end
   end

   typedef struct packed {
      logic [7:0] start;
      logic [7:0] len;
      logic [7:0] addr;
      logic       hbad;
      logic       dbad;
      logic       nrzi;
      logic       junk;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{8'h81, 8'd3, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0},
      '{8'h05, 8'd6, 8'h1A, 1'b0, 1'b0, 1'b1, 1'b0},
      '{8'h90, 8'd2, 8'hC3, 1'b0, 1'b1, 1'b0, 1'b0},
      '{8'h81, 8'd2, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0},
      '{8'h81, 8'd1, 8'h01, 1'b1, 1'b0, 1'b1, 1'b0},
      '{8'h05, 8'd0, 8'hA0, 1'b0, 1'b0, 1'b1, 1'b1},
      '{8'h81, 8'd0, 8'h1F, 1'b0, 1'b0, 1'b0, 1'b0},
      '{8'h90, 8'd4, 8'hA1, 1'b0, 1'b0, 1'b0, 1'b0}
   };

   function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         r = (r[0] != b[i]) ? ((r >> 1) ^ 16'hA001) : (r >> 1);
      end
      return r;
   endfunction

   function automatic bit ref_match(input logic [7:0] a);
      for (int i = 0; i < NA; i++)
         if (((a ^ addr_cmp[i*8 +: 8]) & ~addr_msk[i*8 +: 8]) == 8'h00) return 1'b1;
      return 1'b0;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bump(input int k);
      if (ec[k] < (1 << CW) - 1) ec[k]++;
   endtask

   task automatic send_bit(input logic b);
      if (nrzi_sel) line = b ? line : ~line;
      else          line = b;
      rxd    = line;
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 0; i < 8; i++) send_bit(b[i]);
   endtask

   task automatic clr_cap();
      ncap = 0;
      nstat = 0;
      last_stat = '0;
   endtask

   // cut >= 0: carrier drops after that many data bytes
   task automatic send_msg(input vec_t v, input bit with_syn, input int cut);
      logic [7:0] h [6];
      logic [15:0] c;
      int nd;
      h[0] = v.start; h[1] = v.len; h[2] = 8'hC0; h[3] = 8'h11; h[4] = 8'h22; h[5] = v.addr;
      nd = (v.start == 8'h05) ? 0 : int'(v.len);
      if (with_syn) begin send_byte(SYN); send_byte(SYN); end
      if (v.junk) begin send_byte(8'h42); send_byte(8'h81 ^ 8'h01); end
      c = '0;
      for (int i = 0; i < 6; i++) begin send_byte(h[i]); c = ref_crc(c, h[i]); end
      send_byte(c[7:0] ^ {7'd0, v.hbad});
      send_byte(c[15:8]);
      if (nd > 0) begin
         c = '0;
         for (int i = 0; i < nd; i++) begin
            if (i == cut) begin
               cd = 1'b0;
               repeat (20) @(negedge clk);
               cd = 1'b1;
               return;
            end
            send_byte(8'h30 + 8'(i));
            c = ref_crc(c, 8'h30 + 8'(i));
         end
         send_byte(c[7:0] ^ {7'd0, v.dbad});
         send_byte(c[15:8]);
      end
      for (int i = 0; i < 3; i++) send_byte(8'hFF);
   endtask

   task automatic chk_cnt(input string tag);
      for (int k = 0; k < 4; k++)
         chk(err_cnt[k*CW +: CW] == CW'(ec[k]), tag, int'(err_cnt[k*CW +: CW]), ec[k]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 4; k++) ec[k] = 0;
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(!out_vld && !stat_vld, "R11", int'({out_vld, stat_vld}), 0);
      chk(err_cnt == '0, "R11", int'(err_cnt), 0);
      rst_n = 1'b1;
      rx_en = 1'b1;
      repeat (2) @(negedge clk);

      // table of messages
      for (int n = 0; n < NV; n++) begin
         vec_t v;
         bit acc, hasd;
         int nexp, bad;
         string tag;
         v = VEC[n];
         nrzi_sel = v.nrzi;
         clr_cap();
         send_msg(v, 1'b1, -1);
         hasd = (v.start != 8'h05) && (v.len != 0);
         acc  = !v.hbad && ref_match(v.addr);
         nexp = acc ? (6 + (hasd ? int'(v.len) : 0)) : 0;
         if (v.hbad)           begin tag = "R4"; bump(0); end
         else if (!acc)        begin tag = "R5"; bump(2); end
         else if (hasd)        begin tag = "R7"; if (v.dbad) bump(1); end
         else                        tag = "R6";
         chk(ncap == nexp, tag, ncap, nexp);
         if (v.nrzi) chk(ncap == nexp, "R1", ncap, nexp);
         if (v.junk) chk(ncap == nexp, "R3", ncap, nexp);
         if (acc && ncap == nexp) begin
            bad = 0;
            for (int i = 0; i < nexp; i++) begin
               logic [7:0] e;
               case (i)
                  0: e = v.start; 1: e = v.len; 2: e = 8'hC0;
                  3: e = 8'h11;   4: e = 8'h22; 5: e = v.addr;
                  default: e = 8'h30 + 8'(i - 6);
               endcase
               if (cap_d[i] !== e || cap_f[i] !== (i == 0) || cap_l[i] !== (i == nexp - 1)) bad++;
            end
            chk(bad == 0, tag, bad, 0);
            chk(nstat == 1, tag, nstat, 1);
            chk(last_stat == {1'b0, v.dbad && hasd}, tag, int'(last_stat), int'(v.dbad && hasd));
         end else begin
            chk(nstat == 0, tag, nstat, 0);
         end
         chk_cnt(tag);
      end
      nrzi_sel = 1'b0;

      // R2: no sync pair, nothing comes out
      clr_cap();
      send_msg(VEC[0], 1'b0, -1);
      chk(ncap == 0 && nstat == 0, "R2", ncap + nstat, 0);

      // R9: saturation of counter 0
      for (int i = 0; i < 8; i++) begin
         clr_cap();
         send_msg(VEC[4], 1'b1, -1);
         bump(0);
      end
      chk(err_cnt[0 +: CW] == '1, "R9", int'(err_cnt[0 +: CW]), (1 << CW) - 1);
      // R9: per-counter clear
      cnt_clr = 4'b0001;
      @(negedge clk);
      cnt_clr = 4'b0000;
      ec[0] = 0;
      @(negedge clk);
      chk_cnt("R9");

      // R8: carrier loss after two data bytes of an accepted message
      begin
         vec_t v;
         v = '{8'h81, 8'd5, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0};
         clr_cap();
         send_msg(v, 1'b1, 2);
         bump(3);
         chk(ncap == 8, "R8", ncap, 8);
         chk(nstat == 1 && last_stat == 2'b10, "R8", int'(last_stat), 2);
         chk_cnt("R8");
         repeat (4) send_byte(8'hFF);
         clr_cap();
         send_msg(VEC[0], 1'b1, -1);
         chk(ncap == 9 && last_stat == 2'b00, "R8", ncap, 9);
      end

      // R10: disabled receiver ignores a valid message
      rx_en = 1'b0;
      clr_cap();
      send_msg(VEC[0], 1'b1, -1);
      chk(ncap == 0 && nstat == 0, "R10", ncap + nstat, 0);
      chk_cnt("R10");
      rx_en = 1'b1;

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule